// File: doc/BRIEF.md
# Paged Address Translation Unit with Refill

This block turns a 32-bit logical address into a 28-bit physical address. Pages and frames are 4 KB, so the low 12 bits are an offset within the page and are carried across unchanged. The upper 20 bits are a virtual page number. That number is looked up in a small fully associative cache of recent translations. A matching entry supplies a 16-bit frame number, which is placed above the offset.

Each cached entry carries two flags. A present flag marks the translation as usable. A read-only flag forbids stores to the frame. A request whose page is not cached starts a refill. The unit raises a request toward an external page-table walker and then waits for the walker's answer: a frame number, a present flag and a read-only flag. The unit installs that answer over one entry, chosen in round-robin order, and replies using the fill data.

Only one refill can be in flight at a time. While it is pending, the CPU side sees ready low. A refused access returns a fault code and an all-zero address.

Top module: `tlb_xlate`

## Requirements
- R1: On a successful translation, rsp_paddr[11:0] equals req_vaddr[11:0] and rsp_paddr[27:12] equals the frame number cached for req_vaddr[31:12].
- R2: A request accepted (req_valid and req_ready high at a clock edge) that hits a present entry produces rsp_valid high for exactly the one cycle that follows that edge. It raises no refill request.
- R3: A request accepted that misses sets fill_req high from the next cycle, with fill_vpn equal to req_vaddr[31:12]. Both hold until the edge at which fill_valid is sampled high. While fill_req is high, req_ready is low.
- R4: The edge at which fill_valid is seen during a refill ends the refill. In the next cycle, rsp_valid is high, the reply is built from fill_pfn, fill_present and fill_ro, and fill_req is low. The translation is installed, so a later access to the same page hits without a refill.
- R5: A write (req_write=1) to a read-only page replies with rsp_fault=1, rsp_code=2 and rsp_paddr=0. A read of that page translates normally.
- R6: A refill answered with fill_present=0 replies rsp_fault=1, rsp_code=1 and rsp_paddr=0. It leaves no usable entry behind, so the next access to that page refills again. A successful reply has rsp_code=0 and rsp_fault=0.
- R7: The cache has 8 entries and fills them in round-robin order. After 9 distinct pages are installed following a flush, the first installed page misses and the second still hits.
- R8: A flush cycle invalidates every entry at the next edge and holds req_ready low during that cycle. If a refill completes in the same cycle, the flush wins and nothing is installed, but the reply is still given.
- R9: After reset, req_ready is high, rsp_valid and fill_req are low, and every entry is invalid.
- R10: When a fill reports both not-present and read-only for a write, the not-present code 1 is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_vaddr | input | 32 | Logical address |
| req_write | input | 1 | Request is a store |
| rsp_valid | output | 1 | Reply present (one-cycle pulse) |
| rsp_paddr | output | 28 | Physical address, zero on fault |
| rsp_fault | output | 1 | Access refused |
| rsp_code | output | 2 | 0 ok, 1 not present, 2 write to read-only |
| fill_req | output | 1 | Refill requested from walker |
| fill_vpn | output | 20 | Page number to walk |
| fill_valid | input | 1 | Walker answer present |
| fill_pfn | input | 16 | Frame number from walker |
| fill_present | input | 1 | Walked translation is usable |
| fill_ro | input | 1 | Walked frame is read-only |

## Verification
The bench targets the ninth install after a flush. A wrong replacement pointer would evict a different page, so the second page would miss, or the first would still hit. It repeats accesses to a not-present page, which a design that cached the flag as usable would answer from the cache with a stale frame. It writes to read-only pages through both the cached path and the refill path, where a missing check would return a real address. It also raises flush and checks that ready drops and that every later access refills.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 28,
  parameter int OFS_W   = 12,
  parameter int ENTRIES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic                    req_write,
  output logic                    rsp_valid,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic                    rsp_fault,
  output logic [1:0]              rsp_code,
  output logic                    fill_req,
  output logic [VA_W-OFS_W-1:0]   fill_vpn,
  input  logic                    fill_valid,
  input  logic [PA_W-OFS_W-1:0]   fill_pfn,
  input  logic                    fill_present,
  input  logic                    fill_ro
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PFN_W = PA_W - OFS_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [1:0] CODE_OK = 2'd0;
  localparam logic [1:0] CODE_NP = 2'd1;
  localparam logic [1:0] CODE_WP = 2'd2;

  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, ro_q, hit_vec;
  logic [IDX_W-1:0]   rr_q;
  logic               busy_q, held_wr;
  logic [VA_W-1:0]    held_va;
  logic [PFN_W-1:0]   hit_pfn;
  logic               hit_ro;

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:OFS_W];
  wire accept    = req_valid && req_ready;
  wire fill_done = busy_q && fill_valid;
  wire any_hit   = |hit_vec;

  assign req_ready = !busy_q && !flush;
  assign fill_req  = busy_q;
  assign fill_vpn  = held_va[VA_W-1:OFS_W];
  assign rsp_fault = rsp_code != CODE_OK;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == req_vpn);
  end

  always_comb begin
    hit_pfn = '0;
    hit_ro  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_pfn = hit_pfn | pfn_q[i];
        hit_ro  = hit_ro | ro_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      ro_q    <= '0;
      rr_q    <= '0;
      busy_q  <= 1'b0;
      held_va <= '0;
      held_wr <= 1'b0;
    end else begin
      if (accept && !any_hit) begin
        busy_q  <= 1'b1;
        held_va <= req_vaddr;
        held_wr <= req_write;
      end
      if (fill_done) begin
        busy_q <= 1'b0;
        rr_q   <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        if (!flush) begin
          tag_q[rr_q] <= held_va[VA_W-1:OFS_W];
          pfn_q[rr_q] <= fill_pfn;
          vld_q[rr_q] <= fill_present;
          ro_q[rr_q]  <= fill_ro;
        end
      end
      if (flush) vld_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_code  <= CODE_OK;
    end else begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_code  <= CODE_OK;
      if (accept && any_hit) begin
        rsp_valid <= 1'b1;
        if (req_write && hit_ro) rsp_code <= CODE_WP;
        else rsp_paddr <= {hit_pfn, req_vaddr[OFS_W-1:0]};
      end else if (fill_done) begin
        rsp_valid <= 1'b1;
        if (!fill_present) rsp_code <= CODE_NP;
        else if (held_wr && fill_ro) rsp_code <= CODE_WP;
        else rsp_paddr <= {fill_pfn, held_va[OFS_W-1:0]};
      end
    end
  end

  assert_single_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  assert_fault_no_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_paddr == '0));
  assert_hold_refill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_valid) |=> (fill_req && $stable(fill_vpn)));
  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);
  assert_fill_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && fill_valid) |=> (rsp_valid && !fill_req));
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (hit_vec == '0));
  assert_hit_no_refill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && any_hit) |=> (rsp_valid && !fill_req));
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  logic clk = 0, rst_n = 0, flush = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_fault, fill_req;
  logic [27:0] rsp_paddr;
  logic [1:0] rsp_code;
  logic [19:0] fill_vpn;
  logic fill_valid = 0, fill_present = 0, fill_ro = 0;
  logic [15:0] fill_pfn = '0;

  int total = 0, bad = 0, fills = 0, cycles = 0, wcnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tlb_xlate uut (.clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_code(rsp_code), .fill_req(fill_req), .fill_vpn(fill_vpn),
    .fill_valid(fill_valid), .fill_pfn(fill_pfn), .fill_present(fill_present),
    .fill_ro(fill_ro));

  function automatic logic [15:0] pt_pfn(input logic [19:0] v); return v[15:0] ^ 16'h3C5A; endfunction
  function automatic logic pt_present(input logic [19:0] v); return v[19:16] != 4'hF; endfunction
  function automatic logic pt_ro(input logic [19:0] v); return v[19]; endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // walker: answers a refill three cycles after it appears
  always @(negedge clk) begin
    if (fill_valid) fill_valid <= 0;
    else if (fill_req && rst_n) begin
      wcnt = wcnt + 1;
      if (wcnt >= 3) begin
        wcnt = 0;
        fills++;
        fill_valid   <= 1;
        fill_pfn     <= pt_pfn(fill_vpn);
        fill_present <= pt_present(fill_vpn);
        fill_ro      <= pt_ro(fill_vpn);
      end
    end
  end

  // behavioural reference model, compared on every clock
  logic [19:0] m_tag [8];
  logic [15:0] m_pfn [8];
  bit m_vld [8];
  bit m_ro [8];
  int m_rr;
  bit m_wait, m_wr, m_rv;
  logic [31:0] m_va;
  logic [27:0] m_pa;
  logic [1:0] m_code;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rr = 0; m_wait = 0; m_rv = 0; m_pa = 0; m_code = 0; m_wr = 0; m_va = 0;
      for (int i = 0; i < 8; i++) m_vld[i] = 0;
    end else begin
      bit rdy;
      rdy = !m_wait && !flush;
      m_rv = 0; m_pa = 0; m_code = 0;
      if (rdy && req_valid) begin
        int h;
        h = -1;
        for (int i = 0; i < 8; i++) if (m_vld[i] && m_tag[i] == req_vaddr[31:12]) h = i;
        if (h >= 0) begin
          m_rv = 1;
          if (req_write && m_ro[h]) m_code = 2;
          else m_pa = {m_pfn[h], req_vaddr[11:0]};
        end else begin
          m_wait = 1; m_va = req_vaddr; m_wr = req_write;
        end
      end else if (m_wait && fill_valid) begin
        if (!flush) begin
          m_tag[m_rr] = m_va[31:12]; m_pfn[m_rr] = fill_pfn;
          m_vld[m_rr] = fill_present; m_ro[m_rr] = fill_ro;
        end
        m_rr = (m_rr + 1) % 8;
        m_wait = 0; m_rv = 1;
        if (!fill_present) m_code = 1;
        else if (m_wr && fill_ro) m_code = 2;
        else m_pa = {fill_pfn, m_va[11:0]};
      end
      if (flush) for (int i = 0; i < 8; i++) m_vld[i] = 0;
    end
    #2;
    if (rst_n) begin
      chk(req_ready === (!m_wait && !flush), "R3/R8 req_ready", req_ready, !m_wait && !flush);
      chk(fill_req === m_wait, "R3 fill_req", fill_req, m_wait);
      if (m_wait) chk(fill_vpn === m_va[31:12], "R3 fill_vpn", fill_vpn, m_va[31:12]);
      chk(rsp_valid === m_rv, "R2/R4 rsp_valid", rsp_valid, m_rv);
      chk(rsp_paddr === m_pa, "R1 rsp_paddr", rsp_paddr, m_pa);
      chk(rsp_code === m_code, "R5/R6 rsp_code", rsp_code, m_code);
      chk(rsp_fault === (m_code != 0), "R6 rsp_fault", rsp_fault, m_code != 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic access(input logic [31:0] va, input logic wr,
                        output logic [27:0] pa, output logic [1:0] code, output int nf);
    int f0;
    f0 = fills;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr;
    forever begin
      #1;
      if (req_ready) begin
        @(negedge clk);
        req_valid = 0;
        break;
      end
      @(negedge clk);
    end
    while (!rsp_valid) @(negedge clk);
    pa = rsp_paddr; code = rsp_code; nf = fills - f0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    #1 chk(req_ready == 0, "R8 ready low in flush", req_ready, 0);
    @(negedge clk);
    flush = 0;
  endtask

  initial begin
    logic [27:0] pa;
    logic [1:0] code;
    int nf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R9 ready after reset", req_ready, 1);
    chk(rsp_valid == 0, "R9 rsp_valid after reset", rsp_valid, 0);
    chk(fill_req == 0, "R9 fill_req after reset", fill_req, 0);
    access(32'h1234_5678, 0, pa, code, nf);
    chk(nf == 1, "R9 first access refills", nf, 1);
    chk(pa == {pt_pfn(20'h12345), 12'h678}, "R4 refill reply", pa, {pt_pfn(20'h12345), 12'h678});
    access(32'h1234_5ABC, 0, pa, code, nf);
    chk(nf == 0, "R2 hit without refill", nf, 0);
    chk(pa == {pt_pfn(20'h12345), 12'hABC}, "R1 offset kept", pa, {pt_pfn(20'h12345), 12'hABC});
    access(32'hA000_1010, 0, pa, code, nf);
    chk(code == 0, "R5 read of read-only page", code, 0);
    access(32'hA000_1020, 1, pa, code, nf);
    chk(code == 2 && pa == 0 && nf == 0, "R5 write to cached read-only", {code, pa}, 2 << 28);
    access(32'hA000_5020, 1, pa, code, nf);
    chk(code == 2 && nf == 1, "R5 write read-only via refill", code, 2);
    access(32'hF000_2004, 0, pa, code, nf);
    chk(code == 1 && pa == 0, "R6 not present fault", code, 1);
    access(32'hF000_2008, 0, pa, code, nf);
    chk(nf == 1, "R6 not-present refills again", nf, 1);
    access(32'hF000_3000, 1, pa, code, nf);
    chk(code == 1, "R10 not-present over write-protect", code, 1);
    do_flush();
    access(32'h1234_5000, 0, pa, code, nf);
    chk(nf == 1, "R8 flushed entry misses", nf, 1);
    do_flush();
    for (int k = 0; k < 9; k++) begin
      access({20'h00010 + 20'(k), 12'h004}, 0, pa, code, nf);
      chk(nf == 1, "R7 install distinct page", nf, 1);
    end
    access({20'h00011, 12'h0}, 0, pa, code, nf);
    chk(nf == 0, "R7 second install still hits", nf, 0);
    access({20'h00010, 12'h0}, 0, pa, code, nf);
    chk(nf == 1, "R7 first install evicted", nf, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule